// File: doc/BRIEF.md
# Mailbox transaction sequencer

This block sits on the host side of a byte-wide management register bank and runs one mailbox command against it at a time. The user side hands over a command code, a read flag and a 32-bit argument. The sequencer rings the remote firmware, writes the command and the argument, and presses the doorbell. It then polls a status bit, with a fixed number of attempts and a programmable pause between them. For reads it collects the 32-bit reply. Finally it acknowledges the completion flag. A one-cycle `done` pulse returns the reply together with an error flag.

After reset the block first prepares the bank on its own. It makes sure that completion alerts are not masked. It then runs a "read maximum power limit" command and keeps the result. From then on, every "write power limit" argument is limited to the range from zero to that cached maximum before it is sent. The register side is a simple request/acknowledge handshake. The responder can end any access with an error instead of an acknowledge.

Top module: `mbox_seq`

## Requirements
- R1: After reset the block reads address 0x01. Only if bit 4 of the value read is 1 does it write the same value with bit 4 cleared back to 0x01. Otherwise the next access is the first write of the start-up command.
- R2: After R1 the block runs command 0x04 as a read transaction and caches the returned word as the power-limit maximum. `ready` rises only after that, and no request is accepted before `ready` is high.
- R3: Every transaction writes, in this order: 0x80 to 0x3F, the command byte to 0x38, the argument bytes least significant first to 0x39, 0x3A, 0x3B and 0x3C, and 0x01 to 0x40.
- R4: After the doorbell the block reads 0x02 until bit 1 is 1. It makes at most MAX_POLLS reads, and a new status read starts more than POLL_GAP cycles after the previous one started.
- R5: If bit 1 is still 0 after MAX_POLLS reads, the transaction ends with `err`=1. No reply read and no status write follow.
- R6: For a request with the read flag set, after the status bit is seen the block reads 0x31 to 0x34 and returns them least significant byte first in `rsp_data`.
- R7: The last access of a successful transaction writes to 0x02 the last status value read ORed with 0x02.
- R8: A bus error on any access ends the transaction at once. No further access is made, and `done` returns `err`=1 with `rsp_data`=0.
- R9: For command 0x02 the argument is clamped before it is sent. A value negative as a signed 32-bit number becomes 0, a value above the cached maximum becomes the maximum, and other values pass unchanged.
- R10: `busy` is high from the cycle after a request is accepted until the transaction ends. `done` is a single-cycle pulse with `busy` low. A request presented while `busy` is high waits.
- R11: `bus_req` stays high with address, direction and write data stable until `bus_ack` or `bus_err`, then drops for at least one cycle.
- R12: A successful request with the read flag clear returns `rsp_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| req_valid | input | 1 | request present |
| req_cmd | input | 8 | command code |
| req_rd | input | 1 | 1 = collect a reply word |
| req_data | input | DATA_W | argument word |
| ready | output | 1 | start-up sequence finished |
| busy | output | 1 | transaction in progress |
| done | output | 1 | one-cycle completion pulse |
| err | output | 1 | completion with error, valid with done |
| rsp_data | output | DATA_W | reply word, valid with done |
| bus_req | output | 1 | register access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 8 | register address |
| bus_wdata | output | 8 | write byte |
| bus_ack | input | 1 | access completed |
| bus_err | input | 1 | access failed |
| bus_rdata | input | 8 | read byte, valid with bus_ack |

## Verification
The bench builds the block with DATA_W=32 and MAX_POLLS=11, as the defaults are. It sets POLL_GAP to 4 instead of thousands of cycles. The short gap lets a full eleven-read timeout, and a success on the very last allowed read, finish in about a hundred cycles. Many of them can then be mixed with random commands, arguments near the clamp limit, and bus errors at every position in the access sequence.

// File: rtl/mbox_seq_pkg.sv
package mbox_seq_pkg;
  typedef logic [7:0] byte_t;

  localparam byte_t A_CTRL = 8'h01;
  localparam byte_t A_STAT = 8'h02;
  localparam byte_t A_RSP0 = 8'h31;
  localparam byte_t A_CMD  = 8'h38;
  localparam byte_t A_ARG0 = 8'h39;
  localparam byte_t A_GO   = 8'h3F;
  localparam byte_t A_RING = 8'h40;

  localparam byte_t V_GO   = 8'h80;
  localparam byte_t V_RING = 8'h01;

  localparam int MASK_BIT = 4;
  localparam int FLAG_BIT = 1;

  localparam byte_t CMD_RD_PWR = 8'h01;
  localparam byte_t CMD_WR_LIM = 8'h02;
  localparam byte_t CMD_RD_LIM = 8'h03;
  localparam byte_t CMD_RD_MAX = 8'h04;

  typedef enum logic [3:0] {
    PH_CTRL_RD, PH_CTRL_WR, PH_IDLE, PH_SEQ, PH_POLL,
    PH_WAIT, PH_RESP, PH_CLEAR, PH_FINISH
  } phase_e;
endpackage

// File: rtl/mbox_clamp.sv
module mbox_clamp
  import mbox_seq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [7:0]        cmd,
  input  logic [DATA_W-1:0] din,
  input  logic [DATA_W-1:0] lim,
  output logic [DATA_W-1:0] dout
);
  always_comb begin
    dout = din;
    if (cmd == CMD_WR_LIM) begin
      if (din[DATA_W-1])
        dout = '0;
      else if (din > lim)
        dout = lim;
    end
  end
endmodule

// File: rtl/mbox_gap_timer.sv
module mbox_gap_timer #(
  parameter int GAP = 5000
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expired
);
  localparam int CW = $clog2(GAP + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= CW'(GAP);
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/mbox_step_gen.sv
module mbox_step_gen
  import mbox_seq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3
) (
  input  phase_e            phase,
  input  logic [IDX_W-1:0]  idx,
  input  logic [7:0]        cmd,
  input  logic [DATA_W-1:0] word,
  input  logic [7:0]        ctrl,
  input  logic [7:0]        stat,
  output logic              acc_valid,
  output logic [7:0]        addr,
  output logic              we,
  output logic [7:0]        wdata
);
  localparam int NB = DATA_W / 8;

  always_comb begin
    acc_valid = 1'b0;
    addr      = '0;
    we        = 1'b0;
    wdata     = '0;
    unique case (phase)
      PH_CTRL_RD: begin
        acc_valid = 1'b1;
        addr      = A_CTRL;
      end
      PH_CTRL_WR: begin
        acc_valid = 1'b1;
        we        = 1'b1;
        addr      = A_CTRL;
        wdata     = ctrl & ~(8'h01 << MASK_BIT);
      end
      PH_SEQ: begin
        acc_valid = 1'b1;
        we        = 1'b1;
        if (idx == '0) begin
          addr  = A_GO;
          wdata = V_GO;
        end else if (idx == IDX_W'(1)) begin
          addr  = A_CMD;
          wdata = cmd;
        end else begin
          addr  = A_RING;
          wdata = V_RING;
          for (int b = 0; b < NB; b++) begin
            if (idx == IDX_W'(b + 2)) begin
              addr  = A_ARG0 + 8'(b);
              wdata = word[8*b +: 8];
            end
          end
        end
      end
      PH_POLL: begin
        acc_valid = 1'b1;
        addr      = A_STAT;
      end
      PH_RESP: begin
        acc_valid = 1'b1;
        addr      = A_RSP0 + 8'(idx);
      end
      PH_CLEAR: begin
        acc_valid = 1'b1;
        we        = 1'b1;
        addr      = A_STAT;
        wdata     = stat | (8'h01 << FLAG_BIT);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mbox_seq.sv
module mbox_seq
  import mbox_seq_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int POLL_GAP  = 5000,
  parameter int MAX_POLLS = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [7:0]        req_cmd,
  input  logic              req_rd,
  input  logic [DATA_W-1:0] req_data,
  output logic              ready,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] rsp_data,
  output logic              bus_req,
  output logic              bus_we,
  output logic [7:0]        bus_addr,
  output logic [7:0]        bus_wdata,
  input  logic              bus_ack,
  input  logic              bus_err,
  input  logic [7:0]        bus_rdata
);
  localparam int NB       = DATA_W / 8;
  localparam int SEQ_LAST = NB + 2;
  localparam int IDX_W    = $clog2(SEQ_LAST + 1);
  localparam int PC_W     = $clog2(MAX_POLLS + 1);

  phase_e            state;
  logic [IDX_W-1:0]  idx;
  logic              in_init;
  logic [7:0]        cur_cmd;
  logic              cur_rd;
  logic [DATA_W-1:0] cur_word;
  logic [DATA_W-1:0] acc;
  logic [DATA_W-1:0] max_lim;
  logic [7:0]        ctrl_q;
  logic [7:0]        stat_q;
  logic [PC_W-1:0]   poll_cnt;
  logic              err_q;

  logic              step_valid;
  logic [7:0]        step_addr;
  logic              step_we;
  logic [7:0]        step_wdata;
  logic [DATA_W-1:0] clamped;
  logic              gap_done;
  logic              tmr_load;
  logic              ack_ok;
  logic              hit_err;
  logic              last_poll;

  mbox_step_gen #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_step (
    .phase(state), .idx(idx), .cmd(cur_cmd), .word(cur_word),
    .ctrl(ctrl_q), .stat(stat_q),
    .acc_valid(step_valid), .addr(step_addr), .we(step_we), .wdata(step_wdata)
  );

  mbox_clamp #(.DATA_W(DATA_W)) u_clamp (
    .cmd(req_cmd), .din(req_data), .lim(max_lim), .dout(clamped)
  );

  mbox_gap_timer #(.GAP(POLL_GAP)) u_gap (
    .clk(clk), .rst(rst), .load(tmr_load), .expired(gap_done)
  );

  assign ack_ok    = bus_req && bus_ack && !bus_err;
  assign hit_err   = bus_req && bus_err;
  assign last_poll = (poll_cnt == PC_W'(MAX_POLLS - 1));
  assign tmr_load  = ack_ok && (state == PH_POLL) && !bus_rdata[FLAG_BIT] && !last_poll;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= PH_CTRL_RD;
      idx       <= '0;
      in_init   <= 1'b1;
      cur_cmd   <= '0;
      cur_rd    <= 1'b0;
      cur_word  <= '0;
      acc       <= '0;
      max_lim   <= '0;
      ctrl_q    <= '0;
      stat_q    <= '0;
      poll_cnt  <= '0;
      err_q     <= 1'b0;
      ready     <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      rsp_data  <= '0;
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else begin
      done <= 1'b0;
      if (step_valid && !bus_req) begin
        bus_req   <= 1'b1;
        bus_addr  <= step_addr;
        bus_we    <= step_we;
        bus_wdata <= step_wdata;
      end else if (hit_err) begin
        bus_req <= 1'b0;
        err_q   <= 1'b1;
        state   <= PH_FINISH;
      end else if (ack_ok) begin
        bus_req <= 1'b0;
        unique case (state)
          PH_CTRL_RD: begin
            ctrl_q <= bus_rdata;
            if (bus_rdata[MASK_BIT]) begin
              state <= PH_CTRL_WR;
            end else begin
              cur_cmd  <= CMD_RD_MAX;
              cur_rd   <= 1'b1;
              cur_word <= '0;
              acc      <= '0;
              idx      <= '0;
              state    <= PH_SEQ;
            end
          end
          PH_CTRL_WR: begin
            cur_cmd  <= CMD_RD_MAX;
            cur_rd   <= 1'b1;
            cur_word <= '0;
            acc      <= '0;
            idx      <= '0;
            state    <= PH_SEQ;
          end
          PH_SEQ: begin
            if (idx == IDX_W'(SEQ_LAST)) begin
              poll_cnt <= '0;
              state    <= PH_POLL;
            end else begin
              idx <= idx + 1'b1;
            end
          end
          PH_POLL: begin
            stat_q <= bus_rdata;
            if (bus_rdata[FLAG_BIT]) begin
              idx   <= '0;
              state <= cur_rd ? PH_RESP : PH_CLEAR;
            end else if (last_poll) begin
              err_q <= 1'b1;
              state <= PH_FINISH;
            end else begin
              poll_cnt <= poll_cnt + 1'b1;
              state    <= PH_WAIT;
            end
          end
          PH_RESP: begin
            for (int b = 0; b < NB; b++)
              if (idx == IDX_W'(b)) acc[8*b +: 8] <= bus_rdata;
            if (idx == IDX_W'(NB - 1))
              state <= PH_CLEAR;
            else
              idx <= idx + 1'b1;
          end
          PH_CLEAR: state <= PH_FINISH;
          default: ;
        endcase
      end else begin
        unique case (state)
          PH_WAIT: if (gap_done) state <= PH_POLL;
          PH_IDLE: begin
            if (req_valid) begin
              busy     <= 1'b1;
              cur_cmd  <= req_cmd;
              cur_rd   <= req_rd;
              cur_word <= clamped;
              acc      <= '0;
              err_q    <= 1'b0;
              idx      <= '0;
              state    <= PH_SEQ;
            end
          end
          PH_FINISH: begin
            state <= PH_IDLE;
            err_q <= 1'b0;
            if (in_init) begin
              in_init <= 1'b0;
              ready   <= 1'b1;
              max_lim <= err_q ? '0 : acc;
            end else begin
              busy     <= 1'b0;
              done     <= 1'b1;
              err      <= err_q;
              rsp_data <= (!err_q && cur_rd) ? acc : '0;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/mbox_seq_chk.sv
module mbox_seq_chk
  import mbox_seq_pkg::*;
#(
  parameter int MAX_POLLS = 11
) (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic       ready,
  input logic       busy,
  input logic       done,
  input logic       bus_req,
  input logic       bus_we,
  input logic [7:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic       bus_ack,
  input logic       bus_err
);
  int polls;

  always_ff @(posedge clk) begin
    if (rst)
      polls <= 0;
    else if (bus_req && bus_ack && bus_we && bus_addr == A_GO)
      polls <= 0;
    else if (bus_req && bus_ack && !bus_we && bus_addr == A_STAT)
      polls <= polls + 1;
  end

  // R11
  bus_hold_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_ack && !bus_err |=>
      bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

  // R11
  bus_gap_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req && (bus_ack || bus_err) |=> !bus_req);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R10
  accept_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && ready && !busy |=> busy);

  // R2
  no_early_busy_chk: assert property (@(posedge clk) disable iff (rst)
    !ready |-> !busy && !done);

  // R4
  poll_bound_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_ack && !bus_we && bus_addr == A_STAT |-> polls < MAX_POLLS);
endmodule

bind mbox_seq mbox_seq_chk #(.MAX_POLLS(MAX_POLLS)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .ready(ready), .busy(busy),
  .done(done), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_err(bus_err)
);

// File: tb/mbox_seq_tb.sv
module mbox_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int GAP  = 4;
  localparam int MAXP = 11;
  localparam int DW   = 32;
  localparam logic [31:0] MAXV = 32'd8000;
  localparam int NOERR = 999;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_rd = 1'b0;
  logic [7:0] req_cmd = '0;
  logic [DW-1:0] req_data = '0;
  logic ready, busy, done, err;
  logic [DW-1:0] rsp_data;
  logic bus_req, bus_we, bus_ack = 1'b0, bus_err = 1'b0;
  logic [7:0] bus_addr, bus_wdata, bus_rdata = '0;

  mbox_seq #(.DATA_W(DW), .POLL_GAP(GAP), .MAX_POLLS(MAXP)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_rd(req_rd), .req_data(req_data), .ready(ready), .busy(busy),
    .done(done), .err(err), .rsp_data(rsp_data), .bus_req(bus_req),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;

  // responder model state
  logic [7:0] ctrl_val, stat_base;
  logic [31:0] out_word;
  int nzero, err_k, acc_idx, poll_idx, lat, req_t;
  bit pend = 0;
  logic [7:0] la [0:63];
  logic [7:0] ld [0:63];
  bit lw [0:63];
  int ls [0:63];
  int ln = 0;

  // expected access list
  logic [7:0] ea [0:63];
  logic [7:0] ed [0:63];
  bit ew [0:63];
  int en = 0;

  always @(negedge clk) begin
    if (rst) begin
      bus_ack = 1'b0; bus_err = 1'b0; pend = 0;
    end else if (bus_ack || bus_err) begin
      bus_ack = 1'b0; bus_err = 1'b0;
    end else if (bus_req) begin
      if (!pend) begin pend = 1; lat = $urandom_range(0, 2); req_t = cyc; end
      if (lat > 0) lat--;
      else begin
        pend = 0;
        if (ln < 64) begin
          la[ln] = bus_addr; lw[ln] = bus_we; ld[ln] = bus_wdata; ls[ln] = req_t; ln++;
        end
        if (acc_idx == err_k) bus_err = 1'b1;
        else begin
          bus_ack = 1'b1;
          if (bus_we) begin
            if (bus_addr == 8'h01) ctrl_val = bus_wdata;
          end else if (bus_addr == 8'h01) bus_rdata = ctrl_val;
          else if (bus_addr == 8'h02) begin
            bus_rdata = (poll_idx == nzero) ? (stat_base | 8'h02) : (stat_base & 8'hFD);
            poll_idx++;
          end else if (bus_addr >= 8'h31 && bus_addr <= 8'h34)
            bus_rdata = out_word[8*(bus_addr - 8'h31) +: 8];
          else bus_rdata = 8'h00;
        end
        acc_idx++;
      end
    end
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] clamp_ref(logic [7:0] c, logic [31:0] d);
    if (c != 8'h02) return d;
    if ($signed(d) < 0) return 32'd0;
    if (d > MAXV) return MAXV;
    return d;
  endfunction

  task automatic add_e(logic [7:0] a, bit w, logic [7:0] d);
    ea[en] = a; ew[en] = w; ed[en] = d; en++;
  endtask

  task automatic build_txn(logic [7:0] c, bit rd, logic [31:0] w, int nz, logic [7:0] sb);
    add_e(8'h3F, 1, 8'h80);
    add_e(8'h38, 1, c);
    for (int b = 0; b < 4; b++) add_e(8'h39 + 8'(b), 1, w[8*b +: 8]);
    add_e(8'h40, 1, 8'h01);
    for (int p = 0; p < ((nz >= MAXP) ? MAXP : nz + 1); p++) add_e(8'h02, 0, 8'h00);
    if (nz < MAXP) begin
      if (rd) for (int b = 0; b < 4; b++) add_e(8'h31 + 8'(b), 0, 8'h00);
      add_e(8'h02, 1, sb | 8'h02);
    end
  endtask

  task automatic cmp_log(string tag);
    bit ok = (ln == en);
    int bad = -1;
    for (int i = 0; i < en && i < ln; i++)
      if (la[i] != ea[i] || lw[i] != ew[i] || (ew[i] && ld[i] != ed[i])) begin
        ok = 0; if (bad < 0) bad = i;
      end
    if (!ok && bad >= 0)
      chk(0, {tag, " access"}, {16'(bad), lw[bad] ? 8'h80 : 8'h00, ln[7:0]},
          {la[bad], ld[bad], ea[bad], ed[bad]});
    else chk(ok, {tag, " access count"}, ln, en);
  endtask

  task automatic cmp_gap();
    int prev = -1;
    bit ok = 1;
    bit any = 0;
    for (int i = 0; i < ln; i++)
      if (la[i] == 8'h02 && !lw[i]) begin
        if (prev >= 0) begin any = 1; if (ls[i] - prev <= GAP) ok = 0; end
        prev = ls[i];
      end
    if (any) chk(ok, "R4 poll spacing", 32'(ok), 32'd1);
  endtask

  task automatic prime(int nz, int ek, logic [7:0] sb);
    acc_idx = 0; poll_idx = 0; nzero = nz; err_k = ek; stat_base = sb;
    ln = 0; en = 0;
  endtask

  task automatic do_reset(logic [7:0] ctrl);
    rst = 1'b1;
    ctrl_val = ctrl; out_word = MAXV;
    prime(1, NOERR, 8'h40);
    repeat (3) @(negedge clk);
    chk(!busy && !done && !ready && !bus_req, "R2 reset state",
        {busy, done, ready, bus_req}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    while (!ready) begin
      chk(!busy, "R2 busy before ready", busy, 0);
      @(negedge clk);
    end
    add_e(8'h01, 0, 8'h00);
    if (ctrl[4]) add_e(8'h01, 1, ctrl & 8'hEF);
    build_txn(8'h04, 1, 32'd0, 1, 8'h40);
    cmp_log("R1 R2 init");
    chk(ctrl_val == (ctrl & 8'hEF), "R1 ctrl value", ctrl_val, ctrl & 8'hEF);
  endtask

  task automatic run_txn(logic [7:0] c, logic [31:0] din, int nz, int ek, logic [7:0] sb);
    bit rd = (c != 8'h02);
    int full;
    bit xerr;
    logic [31:0] xrsp;
    prime(nz, ek, sb);
    out_word = $urandom;
    build_txn(c, rd, clamp_ref(c, din), nz, sb);
    full = en;
    xerr = (ek < full) || (nz >= MAXP);
    if (ek < full) en = ek + 1;
    xrsp = xerr ? 32'd0 : (rd ? out_word : 32'd0);
    @(negedge clk);
    req_valid = 1'b1; req_cmd = c; req_rd = rd; req_data = din;
    do @(negedge clk); while (!busy);
    req_valid = 1'b0;
    chk(busy && !done, "R10 busy after accept", busy, 1);
    while (!done) @(negedge clk);
    chk(!busy, "R10 busy low at done", busy, 0);
    chk(err == xerr, "R5 R8 error flag", err, xerr);
    chk(rsp_data == xrsp, "R6 R12 reply word", rsp_data, xrsp);
    cmp_log("R3 R6 R7 R8 R9 sequence");
    cmp_gap();
    @(negedge clk);
    chk(!done, "R10 done single pulse", done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog: done=%0d expected 1", done);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    do_reset(8'h13);            // R1 bit 4 set: write back
    do_reset(8'h05);            // R1 bit 4 clear: no write
    run_txn(8'h03, 32'h0, 0, NOERR, 8'h20);            // R6 R7
    run_txn(8'h02, 32'd9000, 1, NOERR, 8'h00);         // R9 above max
    run_txn(8'h02, 32'hFFFF_FFF0, 0, NOERR, 8'h10);    // R9 negative
    run_txn(8'h02, MAXV, 2, NOERR, 8'h00);             // R9 at max, R12
    run_txn(8'h02, 32'd123, 0, NOERR, 8'h00);          // R9 pass through
    run_txn(8'h01, 32'h0, 10, NOERR, 8'h81);           // R4 last allowed read
    run_txn(8'h01, 32'h0, 11, NOERR, 8'h00);           // R5 timeout
    run_txn(8'h03, 32'h0, 0, 0, 8'h00);                // R8 first access
    run_txn(8'h03, 32'h0, 0, 9, 8'h00);                // R8 during reply
    run_txn(8'h03, 32'h0, 0, 12, 8'h00);               // R8 on clear write
    for (int t = 0; t < 30; t++) begin
      logic [7:0] c = 8'($urandom_range(1, 4));
      logic [31:0] d = ($urandom % 3 == 0) ? MAXV + 32'($urandom_range(0, 2)) - 32'd1 : $urandom;
      int nz = ($urandom % 5 == 0) ? 11 : $urandom_range(0, 4);
      int ek = ($urandom % 6 == 0) ? $urandom_range(0, 16) : NOERR;
      run_txn(c, d, nz, ek, 8'($urandom));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule